// File: doc/BRIEF.md
# Coarse Photon Window Search Controller

This block calibrates the coarse timing of a sync pulse so that single photons seen by a receiver fall inside its narrow acceptance window. It drives two programmable delay lines that sit one after the other. Each time a photon event arrives, the block opens a listening window and waits for the receiver's two valid-photon strobes. If both strobes come back high together, the trial counts as a hit. If the window closes first, the trial counts as a miss.

Decisions are taken by voting over many trials rather than on a single sample. After a set number of misses the block lengthens the delay by one step. The first delay code is stepped until it reaches its ceiling, and only after that is the second code stepped. After a set number of hits in a row, the block saves the current delay and reports that it is done. If both codes are already at their ceiling when another step is needed, the block halts with an error. Every code write and the final save hold a latch strobe for a fixed number of cycles, so the external delay lines can capture the new value.

The block is used once after initialisation. It runs before any fine alignment of the delay, and the result stays in place until the next reset.

Top module: `cps_coarse_search`

## Requirements
- R1: While reset is active and after its release, both delay codes are 0, both latch strobes are low, and `done_o` and `error_o` are low.
- R2: A trial starts only when `photon_i` is high, `init_done_i` is high, the search is neither done nor in error, and no trial or strobe is in progress. Photons seen while `init_done_i` is low change nothing.
- R3: After a trial starts, the block listens for `TIMEOUT` cycles. A trial with no cycle in which `fb_a_i` and `fb_b_i` are both high counts as a miss. Only one of the two strobes being high does not count as a hit.
- R4: When the miss count reaches `VOTE`, the delay is increased by one. `code_a_o` is incremented while it is below `CODE_MAX`.
- R5: Once `code_a_o` equals `CODE_MAX`, each delay increase increments `code_b_o` instead, and `code_a_o` stays at `CODE_MAX`.
- R6: When a delay increase is due and both codes equal `CODE_MAX`, `error_o` rises. It then stays high until reset, and neither code changes again.
- R7: After `VOTE` consecutive hits, both latch strobes are pulsed to save the delay, and then `done_o` rises. `done_o` stays high until reset, and later photons change nothing.
- R8: A missed trial clears the run of consecutive hits.
- R9: Each code write holds only the latch strobe of the code that changed, high for exactly `STROBE` cycles. The save holds both latch strobes high for exactly `STROBE` cycles.
- R10: A delay increase clears both the miss count and the hit count, so the next increase needs `VOTE` fresh misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| photon_i | input | 1 | Photon event, starts a trial |
| init_done_i | input | 1 | Delay lines initialised, search allowed |
| fb_a_i | input | 1 | Receiver valid-photon strobe, channel A |
| fb_b_i | input | 1 | Receiver valid-photon strobe, channel B |
| code_a_o | output | CODE_W | First cascaded delay code |
| code_b_o | output | CODE_W | Second cascaded delay code |
| latch_a_o | output | 1 | Latch strobe for the first delay line |
| latch_b_o | output | 1 | Latch strobe for the second delay line |
| done_o | output | 1 | Coarse search finished, delay saved |
| error_o | output | 1 | Both delay lines exhausted, search halted |

## Verification
The assertions check on every cycle the properties that hold at all times:
- each code only ever moves up by one;
- the second code moves only while the first is at its ceiling;
- a single-line latch strobe rises together with a change in its code;
- done and error are sticky and never high together;
- after an error, both codes are frozen.

Only the bench scenarios can show the behaviour that depends on counting trials:
- that exactly `VOTE` misses cause a step;
- that a miss breaks a run of hits;
- that a single feedback strobe is not a hit;
- that photons before initialisation are ignored;
- that the strobes last exactly `STROBE` cycles.

The bench reaches these by sweeping the whole code space of a small configuration.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_LISTEN = 3'd1,
    S_WRITE  = 3'd2,
    S_SAVE   = 3'd3,
    S_DONE   = 3'd4,
    S_FAULT  = 3'd5
  } cps_state_e;
endpackage

// File: rtl/cps_tick_counter.sv
module cps_tick_counter #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/cps_vote_counter.sv
module cps_vote_counter #(
  parameter int VOTE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int W = $clog2(VOTE + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == W'(VOTE - 1));
endmodule

// File: rtl/cps_delay_cascade.sv
module cps_delay_cascade #(
  parameter int CODE_W   = 10,
  parameter int CODE_MAX = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              a_full,
  output logic              b_full
);
  localparam logic [CODE_W-1:0] MAXC = CODE_W'(CODE_MAX);

  assign a_full = (code_a >= MAXC);
  assign b_full = (code_b >= MAXC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
    end else if (step) begin
      if (!a_full)      code_a <= code_a + 1'b1;
      else if (!b_full) code_b <= code_b + 1'b1;
    end
  end
endmodule

// File: rtl/cps_coarse_search.sv
module cps_coarse_search
  import cps_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int CODE_MAX = 255,
  parameter int TIMEOUT  = 60,
  parameter int VOTE     = 5,
  parameter int STROBE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              photon_i,
  input  logic              init_done_i,
  input  logic              fb_a_i,
  input  logic              fb_b_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              latch_a_o,
  output logic              latch_b_o,
  output logic              done_o,
  output logic              error_o
);
  cps_state_e st, st_nxt;
  logic [1:0] sel, sel_nxt;
  logic tmr_clr, tmr_en, tmr_last;
  logic str_clr, str_en, str_last;
  logic hit_inc, hit_clr, hit_last;
  logic miss_inc, miss_clr, miss_last;
  logic step, a_full, b_full;
  logic both_hit;

  assign both_hit = fb_a_i & fb_b_i;

  cps_tick_counter #(.LIMIT(TIMEOUT)) u_timeout (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .last(tmr_last));

  cps_tick_counter #(.LIMIT(STROBE)) u_strobe (
    .clk(clk), .rst_n(rst_n), .clr(str_clr), .en(str_en), .last(str_last));

  cps_vote_counter #(.VOTE(VOTE)) u_hits (
    .clk(clk), .rst_n(rst_n), .clr(hit_clr), .inc(hit_inc), .at_last(hit_last));

  cps_vote_counter #(.VOTE(VOTE)) u_misses (
    .clk(clk), .rst_n(rst_n), .clr(miss_clr), .inc(miss_inc), .at_last(miss_last));

  cps_delay_cascade #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_delay (
    .clk(clk), .rst_n(rst_n), .step(step),
    .code_a(code_a_o), .code_b(code_b_o), .a_full(a_full), .b_full(b_full));

  always_comb begin
    st_nxt   = st;
    sel_nxt  = sel;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    str_clr  = 1'b0;
    str_en   = 1'b0;
    hit_inc  = 1'b0;
    hit_clr  = 1'b0;
    miss_inc = 1'b0;
    miss_clr = 1'b0;
    step     = 1'b0;
    unique case (st)
      S_IDLE: begin
        tmr_clr = 1'b1;
        if (photon_i && init_done_i) st_nxt = S_LISTEN;
      end
      S_LISTEN: begin
        tmr_en = 1'b1;
        if (both_hit) begin
          hit_inc = 1'b1;
          if (hit_last) begin
            st_nxt  = S_SAVE;
            sel_nxt = 2'b11;
            str_clr = 1'b1;
          end else begin
            st_nxt = S_IDLE;
          end
        end else if (tmr_last) begin
          hit_clr  = 1'b1;
          miss_inc = 1'b1;
          st_nxt   = S_IDLE;
          if (miss_last) begin
            miss_clr = 1'b1;
            if (a_full && b_full) begin
              st_nxt = S_FAULT;
            end else begin
              step    = 1'b1;
              sel_nxt = a_full ? 2'b10 : 2'b01;
              st_nxt  = S_WRITE;
              str_clr = 1'b1;
            end
          end
        end
      end
      S_WRITE: begin
        str_en = 1'b1;
        if (str_last) st_nxt = S_IDLE;
      end
      S_SAVE: begin
        str_en = 1'b1;
        if (str_last) st_nxt = S_DONE;
      end
      S_DONE:  st_nxt = S_DONE;
      S_FAULT: st_nxt = S_FAULT;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sel <= 2'b00;
    end else begin
      st  <= st_nxt;
      sel <= sel_nxt;
    end
  end

  assign latch_a_o = ((st == S_WRITE) || (st == S_SAVE)) && sel[0];
  assign latch_b_o = ((st == S_WRITE) || (st == S_SAVE)) && sel[1];
  assign done_o    = (st == S_DONE);
  assign error_o   = (st == S_FAULT);
endmodule

// File: rtl/cps_coarse_search_chk.sv
module cps_coarse_search_chk #(
  parameter int CODE_W   = 10,
  parameter int CODE_MAX = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              latch_a_o,
  input logic              latch_b_o,
  input logic              done_o,
  input logic              error_o
);
  a_r4_code_a_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a_o != $past(code_a_o)) |-> (code_a_o == $past(code_a_o) + 1'b1));

  a_r5_code_b_after_a_full: assert property (@(posedge clk) disable iff (!rst_n)
    (code_b_o != $past(code_b_o)) |->
      ((code_b_o == $past(code_b_o) + 1'b1) && ($past(code_a_o) == CODE_W'(CODE_MAX))));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);

  a_r6_error_freezes_codes: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> ($stable(code_a_o) && $stable(code_b_o)));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  a_r7_done_error_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  a_r9_latch_a_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch_a_o) && !latch_b_o) |-> (code_a_o != $past(code_a_o)));

  a_r9_latch_b_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch_b_o) && !latch_a_o) |-> (code_b_o != $past(code_b_o)));
endmodule

bind cps_coarse_search cps_coarse_search_chk #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_a_o(code_a_o), .code_b_o(code_b_o),
  .latch_a_o(latch_a_o), .latch_b_o(latch_b_o), .done_o(done_o), .error_o(error_o));

// File: tb/tb_cps_coarse_search.sv
module tb_cps_coarse_search;
  localparam int CODE_W   = 4;
  localparam int CODE_MAX = 3;
  localparam int TIMEOUT  = 6;
  localparam int VOTE     = 3;
  localparam int STROBE   = 3;

  logic clk, rst_n, photon, init_done, fb_a, fb_b;
  logic [CODE_W-1:0] code_a, code_b;
  logic latch_a, latch_b, done, error;

  int checks = 0;
  int fails  = 0;
  int exp_a, exp_b, exp_miss, exp_hit, exp_la, exp_lb;
  bit exp_done, exp_err;

  cps_coarse_search #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .TIMEOUT(TIMEOUT),
                      .VOTE(VOTE), .STROBE(STROBE)) dut (
    .clk(clk), .rst_n(rst_n), .photon_i(photon), .init_done_i(init_done),
    .fb_a_i(fb_a), .fb_b_i(fb_b), .code_a_o(code_a), .code_b_o(code_b),
    .latch_a_o(latch_a), .latch_b_o(latch_b), .done_o(done), .error_o(error));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    exp_a = 0; exp_b = 0; exp_miss = 0; exp_hit = 0;
    exp_done = 0; exp_err = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; photon = 0; init_done = 0; fb_a = 0; fb_b = 0;
    repeat (3) @(negedge clk);
    chk(code_a == 0 && code_b == 0, "R1 codes in reset", {code_a, code_b}, 0);
    chk(!latch_a && !latch_b && !done && !error, "R1 flags in reset",
        {latch_a, latch_b, done, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_a == 0 && code_b == 0 && !done && !error, "R1 after release",
        {code_a, code_b, done, error}, 0);
    model_reset();
  endtask

  // mode 0: no feedback, 1: both strobes, 2: only fb_a
  task automatic run_trial(input int mode, input string tag);
    int la = 0;
    int lb = 0;
    exp_la = 0; exp_lb = 0;
    @(negedge clk);
    photon = 1'b1;
    @(negedge clk);
    photon = 1'b0;
    if (mode == 1) begin fb_a = 1'b1; fb_b = 1'b1; end
    if (mode == 2) fb_a = 1'b1;
    for (int i = 0; i < TIMEOUT + STROBE + 6; i++) begin
      @(negedge clk);
      if (mode == 1) begin fb_a = 1'b0; fb_b = 1'b0; end
      if (latch_a) la++;
      if (latch_b) lb++;
    end
    fb_a = 1'b0; fb_b = 1'b0;
    // expected behaviour
    if (init_done && !exp_done && !exp_err) begin
      if (mode == 1) begin
        exp_hit++;
        if (exp_hit == VOTE) begin
          exp_done = 1; exp_la = STROBE; exp_lb = STROBE;
        end
      end else begin
        exp_hit = 0;
        exp_miss++;
        if (exp_miss == VOTE) begin
          exp_miss = 0;
          if (exp_a < CODE_MAX) begin exp_a++; exp_la = STROBE; end
          else if (exp_b < CODE_MAX) begin exp_b++; exp_lb = STROBE; end
          else exp_err = 1;
        end
      end
    end
    chk(code_a == exp_a, (exp_a == CODE_MAX) ? "R5 code_a held" : "R4 code_a",
        code_a, exp_a);
    chk(code_b == exp_b, "R5 code_b", code_b, exp_b);
    chk(la == exp_la && lb == exp_lb, "R9 latch strobe cycles", la * 100 + lb,
        exp_la * 100 + exp_lb);
    chk(done == exp_done && error == exp_err, tag, {done, error}, {exp_done, exp_err});
  endtask

  initial begin
    do_reset();
    // R2: no trials before init done
    for (int i = 0; i < VOTE + 1; i++) run_trial(0, "R2 ignored before init");
    chk(code_a == 0, "R2 code unchanged without init", code_a, 0);
    init_done = 1'b1;
    // R8: a miss breaks the run of hits
    for (int i = 0; i < VOTE - 1; i++) run_trial(1, "R7 hit run");
    run_trial(0, "R8 miss breaks run");
    for (int i = 0; i < VOTE - 1; i++) run_trial(1, "R8 run restarted, not done");
    chk(!done, "R8 not done after broken run", done, 0);
    run_trial(0, "R3 miss");
    run_trial(2, "R3 single strobe is a miss");
    chk(code_a == 1, "R4 step after vote of misses", code_a, 1);
    // R10: counters cleared by the step
    for (int i = 0; i < VOTE - 1; i++) run_trial(0, "R10 fresh misses");
    chk(code_a == 1, "R10 no early step", code_a, 1);
    run_trial(0, "R10 step on fresh vote");
    // sweep the rest of the code space into error
    for (int i = 0; i < 40; i++) begin
      int m;
      m = (i % 3 == 1) ? 1 : ((i % 4 == 0) ? 2 : 0);
      run_trial(m, exp_err ? "R6 error sticky" : "R3 sweep");
    end
    chk(error == 1 && code_a == CODE_MAX && code_b == CODE_MAX, "R6 exhausted",
        {error, code_a, code_b}, {1'b1, CODE_W'(CODE_MAX), CODE_W'(CODE_MAX)});
    // save path
    do_reset();
    init_done = 1'b1;
    for (int i = 0; i < VOTE; i++) run_trial(0, "R4 miss");
    for (int i = 0; i < VOTE; i++) run_trial(1, "R7 hit vote");
    chk(done == 1, "R7 done after vote of hits", done, 1);
    run_trial(0, "R7 done sticky after miss");
    run_trial(1, "R7 done sticky after hit");
    chk(code_a == 1 && code_b == 0, "R7 codes frozen when done", code_a, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule